// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the machine-control and status state of one processor strand behind a single indexed access port. Each cycle the pipeline may present one access: a 5-bit register index, a read/write flag, 64-bit write data and the privilege of the requester (user, supervisor or hypervisor). In the same cycle the block answers with read data and a 3-bit fault code. A write lands on the next rising clock edge, and only when the fault code is "none".

Some of the state depends on the current trap level. The trap-return PC, next-PC, saved state and trap-type registers are banked, with one slot per trap level, and an access always reaches slot (level - 1). Writes to the trap level and the global-register level saturate at limits that depend on privilege. The trap base address register keeps only its upper bits. The tick register does not count by itself. It stores an offset from a free-running 63-bit cycle counter, so a read returns the cycles elapsed since the last write plus the value written. A hide bit in bit 63 blocks user reads. Writes to the window pointer and to the global level each produce a one-cycle change pulse, which the register-window logic outside this block consumes.

Top module: `ctl_regfile`

## Requirements
- R1: After reset, reads in hypervisor mode return these values. Trap level (index 16) is MAX_TL (6). Global level (index 19) is MAX_GL (3). Hypervisor state (index 20) is 0x24, which is the red bit 5 plus the hyper bit 2. Soft interrupt (index 6) is 0. The trap-type slot of the top level (index 13 at level 6) holds 1, the power-on code.
- R2: After reset, all three timer-compare registers (indices 7, 8, 9) read 0x8000_0000_0000_0000: interrupt disable in bit 63, compare field zero.
- R3: The trap-stack registers (index 10 PC, 11 next-PC, 12 state, 13 type) access slot (level - 1). A value written at one level is not seen at another level and does not disturb it.
- R4: A trap-stack access while the level is 0 or above MAX_TL gives fault 3 (illegal). The read returns 0 and a write changes nothing. Any faulting read returns 0.
- R5: A trap-level write saturates at MAX_TL (6) in hypervisor mode (privilege 2 or 3) and at MAX_PTL (2) in supervisor mode (privilege 1). In user mode (privilege 0) the value is stored as given.
- R6: A global-level write saturates in the same way at MAX_GL (3) and MAX_PGL (2). In the cycle after each accepted write, glob_chg_o is high for one cycle and glob_lvl_o shows the stored level.
- R7: A write to the trap base register (index 14) clears bits 14:0, and the register reads back with those bits zero.
- R8: The version register (index 22) reads NWIN in bits 7:0, MAX_TL in bits 15:8 and MAX_GL in bits 23:16, which is 0x030608 by default. A write to it gives fault 3 and changes nothing.
- R9: The tick register (index 3) reads as (cycle counter - offset) with the hide bit in bit 63. A write of V sets the offset so that the read one cycle later returns V[62:0]+1 and grows by one each cycle, and bit 63 of V becomes the hide bit. Reset sets the hide bit.
- R10: A tick access is refused in these cases. A user read with the hide bit set gives fault 1 (privileged action) and data 0. A user write gives fault 2 (privileged opcode). A supervisor write gives fault 1. Only a hypervisor write takes effect.
- R11: A window-pointer write (index 18) stores the value. In the next cycle win_chg_o pulses for one cycle with win_ptr_o equal to the stored value.
- R12: Any access to the PC index (4) gives fault 3. The performance-counter index (5) and indices 23 to 31 give fault 4 (unimplemented).
- R13: The fault code applies to the access presented in the same cycle and is 0 when acc_valid is low. A write with a nonzero fault, or with acc_valid low, leaves all state unchanged. Accepted writes to plain registers such as index 0 read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 5 | Register index |
| acc_wdata | input | 64 | Write data |
| acc_priv | input | 2 | 0 user, 1 supervisor, 2/3 hypervisor |
| rd_data_o | output | 64 | Read data, zero on fault |
| fault_o | output | 3 | 0 none, 1 priv action, 2 priv opcode, 3 illegal, 4 unimplemented |
| win_chg_o | output | 1 | One-cycle pulse after a window-pointer write |
| win_ptr_o | output | WPW (3) | Current window pointer |
| glob_chg_o | output | 1 | One-cycle pulse after a global-level write |
| glob_lvl_o | output | GLW (2) | Current global level |

## Verification
The assertions watch several properties every cycle. A faulting or invalid write leaves the level, base and plain registers unchanged. A faulting read returns zero. A supervisor trap-level write never lands above MAX_PTL. Each accepted window-pointer or global-level write produces its pulse one cycle later. The cycle counter steps by one per clock, and the trap bank is never written while the level is out of range. Other behaviour can only be shown by the bench's scenarios: which bank slot a given level reaches, the reset contents, the exact saturation values per privilege, the tick arithmetic across several cycles, and the fault code chosen for each index and privilege combination.

// File: rtl/ctl_regfile_pkg.sv
package ctl_regfile_pkg;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_PRV_ACT  = 3'd1,
        FLT_PRV_OPC  = 3'd2,
        FLT_ILLEGAL  = 3'd3,
        FLT_UNIMP    = 3'd4
    } fault_e;

    typedef enum logic [4:0] {
        IDX_YREG     = 5'd0,
        IDX_CCODE    = 5'd1,
        IDX_ASPACE   = 5'd2,
        IDX_TICK     = 5'd3,
        IDX_PC       = 5'd4,
        IDX_PERF     = 5'd5,
        IDX_SOFTINT  = 5'd6,
        IDX_TCMP     = 5'd7,
        IDX_STCMP    = 5'd8,
        IDX_HTCMP    = 5'd9,
        IDX_TS_PC    = 5'd10,
        IDX_TS_NPC   = 5'd11,
        IDX_TS_STATE = 5'd12,
        IDX_TS_TYPE  = 5'd13,
        IDX_TBASE    = 5'd14,
        IDX_PSTATE   = 5'd15,
        IDX_TLEVEL   = 5'd16,
        IDX_PIL      = 5'd17,
        IDX_WINPTR   = 5'd18,
        IDX_GLEVEL   = 5'd19,
        IDX_HPSTATE  = 5'd20,
        IDX_HTBASE   = 5'd21,
        IDX_HVER     = 5'd22
    } idx_e;

    localparam logic [63:0] CMP_RESET   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] HPST_RESET  = 64'h0000_0000_0000_0024;
    localparam logic [63:0] TBASE_KEEP  = 64'hFFFF_FFFF_FFFF_8000;

    function automatic logic is_trap_stack(input logic [4:0] idx);
        return (idx == IDX_TS_PC) || (idx == IDX_TS_NPC) ||
               (idx == IDX_TS_STATE) || (idx == IDX_TS_TYPE);
    endfunction

endpackage

// File: rtl/ctl_access_check.sv
module ctl_access_check
    import ctl_regfile_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int TLW    = 3
) (
    input  logic           valid,
    input  logic           write,
    input  logic [4:0]     idx,
    input  logic [1:0]     priv,
    input  logic [TLW-1:0] tl,
    input  logic           tick_hide,
    output fault_e         fault
);
    localparam logic [TLW-1:0] TL_TOP = TLW'(MAX_TL);

    logic is_user;
    logic is_super;
    logic tl_ok;

    assign is_user  = (priv == 2'b00);
    assign is_super = (priv == 2'b01);
    assign tl_ok    = (tl != '0) && (tl <= TL_TOP);

    always_comb begin
        fault = FLT_NONE;
        if (valid) begin
            case (idx)
                IDX_YREG, IDX_CCODE, IDX_ASPACE, IDX_SOFTINT, IDX_TCMP,
                IDX_STCMP, IDX_HTCMP, IDX_TBASE, IDX_PSTATE, IDX_TLEVEL,
                IDX_PIL, IDX_WINPTR, IDX_GLEVEL, IDX_HPSTATE, IDX_HTBASE:
                    fault = FLT_NONE;
                IDX_TICK: begin
                    if (write) begin
                        if (is_user)       fault = FLT_PRV_OPC;
                        else if (is_super) fault = FLT_PRV_ACT;
                    end else if (is_user && tick_hide) begin
                        fault = FLT_PRV_ACT;
                    end
                end
                IDX_TS_PC, IDX_TS_NPC, IDX_TS_STATE, IDX_TS_TYPE:
                    if (!tl_ok) fault = FLT_ILLEGAL;
                IDX_PC:   fault = FLT_ILLEGAL;
                IDX_HVER: if (write) fault = FLT_ILLEGAL;
                default:  fault = FLT_UNIMP;
            endcase
        end
    end

    // R13: with no access presented there is never a fault
    always_comb begin
        if (!valid) a_r13_idle_no_fault: assert (fault == FLT_NONE);
    end
endmodule

// File: rtl/ctl_tick_unit.sv
module ctl_tick_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [63:0] wdata,
    output logic [63:0] rd_val,
    output logic        hide
);
    typedef struct packed {
        logic [62:0] cyc;
        logic [62:0] ofs;
        logic        hide;
    } tick_t;

    tick_t tk_d, tk_q;

    always_comb begin
        tk_d     = tk_q;
        tk_d.cyc = tk_q.cyc + 63'd1;
        if (wr_en) begin
            tk_d.ofs  = tk_q.cyc - wdata[62:0];
            tk_d.hide = wdata[63];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tk_q      <= '0;
            tk_q.hide <= 1'b1;
        end else begin
            tk_q <= tk_d;
        end
    end

    assign rd_val = {tk_q.hide, tk_q.cyc - tk_q.ofs};
    assign hide   = tk_q.hide;

    // R9: the cycle base advances by exactly one per clock
    a_r9_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tk_q.cyc == $past(tk_q.cyc) + 63'd1);

    // R9: one cycle after a write the count reads the written value plus one
    a_r9_write_offset: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_val == {$past(wdata[63]), $past(wdata[62:0]) + 63'd1});
endmodule

// File: rtl/ctl_trap_bank.sv
module ctl_trap_bank #(
    parameter int          MAX_TL   = 6,
    parameter int          TLW      = 3,
    parameter logic [63:0] POR_CODE = 64'd1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TLW-1:0] tl,
    input  logic [1:0]     fld,
    input  logic           wr_en,
    input  logic [63:0]    wdata,
    output logic [63:0]    rd_val
);
    localparam logic [TLW-1:0] TL_TOP = TLW'(MAX_TL);

    typedef struct packed {
        logic [63:0] pc;
        logic [63:0] npc;
        logic [63:0] st;
        logic [63:0] ty;
    } slot_t;

    slot_t bank_d [MAX_TL];
    slot_t bank_q [MAX_TL];

    logic           in_range;
    logic [TLW-1:0] slot;

    assign in_range = (tl != '0) && (tl <= TL_TOP);
    assign slot     = tl - TLW'(1);

    always_comb begin
        bank_d = bank_q;
        rd_val = '0;
        for (int i = 0; i < MAX_TL; i++) begin
            if (in_range && slot == TLW'(i)) begin
                case (fld)
                    2'd0:    rd_val = bank_q[i].pc;
                    2'd1:    rd_val = bank_q[i].npc;
                    2'd2:    rd_val = bank_q[i].st;
                    default: rd_val = bank_q[i].ty;
                endcase
                if (wr_en) begin
                    case (fld)
                        2'd0:    bank_d[i].pc  = wdata;
                        2'd1:    bank_d[i].npc = wdata;
                        2'd2:    bank_d[i].st  = wdata;
                        default: bank_d[i].ty  = wdata;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_TL; i++) bank_q[i] <= '0;
            bank_q[MAX_TL-1].ty <= POR_CODE;
        end else begin
            bank_q <= bank_d;
        end
    end

    // R4: the bank is only written while the level selects a real slot
    a_r4_bank_guard: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> in_range);
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import ctl_regfile_pkg::*;
#(
    parameter int          MAX_TL   = 6,
    parameter int          MAX_PTL  = 2,
    parameter int          MAX_GL   = 3,
    parameter int          MAX_PGL  = 2,
    parameter int          NWIN     = 8,
    parameter logic [63:0] POR_CODE = 64'd1,
    localparam int         TLW      = $clog2(MAX_TL + 1),
    localparam int         GLW      = $clog2(MAX_GL + 1),
    localparam int         WPW      = $clog2(NWIN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_valid,
    input  logic           acc_write,
    input  logic [4:0]     acc_idx,
    input  logic [63:0]    acc_wdata,
    input  logic [1:0]     acc_priv,
    output logic [63:0]    rd_data_o,
    output logic [2:0]     fault_o,
    output logic           win_chg_o,
    output logic [WPW-1:0] win_ptr_o,
    output logic           glob_chg_o,
    output logic [GLW-1:0] glob_lvl_o
);
    localparam logic [63:0] VER_WORD =
        {40'd0, 8'(MAX_GL), 8'(MAX_TL), 8'(NWIN)};

    typedef struct packed {
        logic [63:0]    yreg;
        logic [7:0]     ccode;
        logic [7:0]     aspace;
        logic [63:0]    softint;
        logic [63:0]    tcmp;
        logic [63:0]    stcmp;
        logic [63:0]    htcmp;
        logic [63:0]    tbase;
        logic [63:0]    pstate;
        logic [TLW-1:0] tl;
        logic [3:0]     pil;
        logic [WPW-1:0] wp;
        logic [GLW-1:0] gl;
        logic [63:0]    hpstate;
        logic [63:0]    htbase;
        logic           win_chg;
        logic           glob_chg;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    fault_e         fault_w;
    logic           commit;
    logic           ts_wr;
    logic           tick_wr;
    logic [1:0]     ts_fld;
    logic [63:0]    ts_rd;
    logic [63:0]    tick_rd;
    logic           tick_hide;
    logic [TLW-1:0] tl_new;
    logic [GLW-1:0] gl_new;
    logic [63:0]    rd_mux;

    ctl_access_check #(.MAX_TL(MAX_TL), .TLW(TLW)) u_check (
        .valid     (acc_valid),
        .write     (acc_write),
        .idx       (acc_idx),
        .priv      (acc_priv),
        .tl        (st_q.tl),
        .tick_hide (tick_hide),
        .fault     (fault_w)
    );

    assign commit  = acc_valid && acc_write && (fault_w == FLT_NONE);
    assign ts_wr   = commit && is_trap_stack(acc_idx);
    assign tick_wr = commit && (acc_idx == IDX_TICK);
    assign ts_fld  = acc_idx[1:0] - 2'd2;   // 10..13 -> 0..3

    ctl_trap_bank #(.MAX_TL(MAX_TL), .TLW(TLW), .POR_CODE(POR_CODE)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .tl     (st_q.tl),
        .fld    (ts_fld),
        .wr_en  (ts_wr),
        .wdata  (acc_wdata),
        .rd_val (ts_rd)
    );

    ctl_tick_unit u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tick_wr),
        .wdata  (acc_wdata),
        .rd_val (tick_rd),
        .hide   (tick_hide)
    );

    // Privilege-dependent saturation of level writes
    always_comb begin
        if (acc_priv[1])
            tl_new = (acc_wdata > 64'(MAX_TL)) ? TLW'(MAX_TL) : acc_wdata[TLW-1:0];
        else if (acc_priv[0])
            tl_new = (acc_wdata > 64'(MAX_PTL)) ? TLW'(MAX_PTL) : acc_wdata[TLW-1:0];
        else
            tl_new = acc_wdata[TLW-1:0];

        if (acc_priv[1])
            gl_new = (acc_wdata > 64'(MAX_GL)) ? GLW'(MAX_GL) : acc_wdata[GLW-1:0];
        else if (acc_priv[0])
            gl_new = (acc_wdata > 64'(MAX_PGL)) ? GLW'(MAX_PGL) : acc_wdata[GLW-1:0];
        else
            gl_new = acc_wdata[GLW-1:0];
    end

    always_comb begin
        st_d          = st_q;
        st_d.win_chg  = 1'b0;
        st_d.glob_chg = 1'b0;
        if (commit) begin
            case (acc_idx)
                IDX_YREG:    st_d.yreg    = acc_wdata;
                IDX_CCODE:   st_d.ccode   = acc_wdata[7:0];
                IDX_ASPACE:  st_d.aspace  = acc_wdata[7:0];
                IDX_SOFTINT: st_d.softint = acc_wdata;
                IDX_TCMP:    st_d.tcmp    = acc_wdata;
                IDX_STCMP:   st_d.stcmp   = acc_wdata;
                IDX_HTCMP:   st_d.htcmp   = acc_wdata;
                IDX_TBASE:   st_d.tbase   = acc_wdata & TBASE_KEEP;
                IDX_PSTATE:  st_d.pstate  = acc_wdata;
                IDX_TLEVEL:  st_d.tl      = tl_new;
                IDX_PIL:     st_d.pil     = acc_wdata[3:0];
                IDX_WINPTR: begin
                    st_d.wp      = acc_wdata[WPW-1:0];
                    st_d.win_chg = 1'b1;
                end
                IDX_GLEVEL: begin
                    st_d.gl       = gl_new;
                    st_d.glob_chg = 1'b1;
                end
                IDX_HPSTATE: st_d.hpstate = acc_wdata;
                IDX_HTBASE:  st_d.htbase  = acc_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.tl      <= TLW'(MAX_TL);
            st_q.gl      <= GLW'(MAX_GL);
            st_q.tcmp    <= CMP_RESET;
            st_q.stcmp   <= CMP_RESET;
            st_q.htcmp   <= CMP_RESET;
            st_q.hpstate <= HPST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (acc_idx)
            IDX_YREG:    rd_mux = st_q.yreg;
            IDX_CCODE:   rd_mux = {56'd0, st_q.ccode};
            IDX_ASPACE:  rd_mux = {56'd0, st_q.aspace};
            IDX_TICK:    rd_mux = tick_rd;
            IDX_SOFTINT: rd_mux = st_q.softint;
            IDX_TCMP:    rd_mux = st_q.tcmp;
            IDX_STCMP:   rd_mux = st_q.stcmp;
            IDX_HTCMP:   rd_mux = st_q.htcmp;
            IDX_TS_PC, IDX_TS_NPC, IDX_TS_STATE, IDX_TS_TYPE:
                         rd_mux = ts_rd;
            IDX_TBASE:   rd_mux = st_q.tbase & TBASE_KEEP;
            IDX_PSTATE:  rd_mux = st_q.pstate;
            IDX_TLEVEL:  rd_mux = 64'(st_q.tl);
            IDX_PIL:     rd_mux = {60'd0, st_q.pil};
            IDX_WINPTR:  rd_mux = 64'(st_q.wp);
            IDX_GLEVEL:  rd_mux = 64'(st_q.gl);
            IDX_HPSTATE: rd_mux = st_q.hpstate;
            IDX_HTBASE:  rd_mux = st_q.htbase;
            IDX_HVER:    rd_mux = VER_WORD;
            default:     rd_mux = '0;
        endcase
    end

    assign rd_data_o  = (fault_w == FLT_NONE) ? rd_mux : '0;
    assign fault_o    = fault_w;
    assign win_chg_o  = st_q.win_chg;
    assign win_ptr_o  = st_q.wp;
    assign glob_chg_o = st_q.glob_chg;
    assign glob_lvl_o = st_q.gl;

    // R13: a refused or invalid write leaves architectural state untouched
    a_r13_refused_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write && (!acc_valid || fault_o != 3'd0)) |=>
        ($stable(st_q.tl) && $stable(st_q.gl) && $stable(st_q.yreg) &&
         $stable(st_q.tbase) && $stable(st_q.wp)));

    // R4: a faulting access never returns data
    a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o != 3'd0) |-> (rd_data_o == 64'd0));

    // R5: supervisor trap-level writes land at or below the supervisor cap
    a_r5_super_tl_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && acc_idx == IDX_TLEVEL && acc_priv == 2'b01) |=>
        (st_q.tl <= TLW'(MAX_PTL)));

    // R6: an accepted global-level write pulses the change output next cycle
    a_r6_glob_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && acc_idx == IDX_GLEVEL) |=> glob_chg_o);

    // R11: an accepted window write pulses with the written pointer
    a_r11_win_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && acc_idx == IDX_WINPTR) |=>
        (win_chg_o && win_ptr_o == $past(acc_wdata[WPW-1:0])));

    // R7: the low base bits stay clear at all times
    a_r7_tbase_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tbase[14:0] == 15'd0);
endmodule

// File: tb/ctl_regfile_bench.sv
`timescale 1ns/1ps
module ctl_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic        acc_write;
    logic [4:0]  acc_idx;
    logic [63:0] acc_wdata;
    logic [1:0]  acc_priv;
    logic [63:0] rd_data_o;
    logic [2:0]  fault_o;
    logic        win_chg_o;
    logic [2:0]  win_ptr_o;
    logic        glob_chg_o;
    logic [1:0]  glob_lvl_o;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] got_rd;
    logic [2:0]  got_flt;

    localparam logic [1:0] U = 2'd0, S = 2'd1, H = 2'd2;

    always #10 clk = ~clk;

    ctl_regfile u_ctl_regfile (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
        .rd_data_o(rd_data_o), .fault_o(fault_o), .win_chg_o(win_chg_o),
        .win_ptr_o(win_ptr_o), .glob_chg_o(glob_chg_o), .glob_lvl_o(glob_lvl_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic v, input logic w, input logic [4:0] idx,
                          input logic [63:0] d, input logic [1:0] p);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_idx = idx; acc_wdata = d; acc_priv = p;
        #2;
        got_rd  = rd_data_o;
        got_flt = fault_o;
    endtask

    task automatic rd(input logic [4:0] idx, input logic [1:0] p);
        access(1'b1, 1'b0, idx, 64'd0, p);
    endtask

    task automatic wr(input logic [4:0] idx, input logic [63:0] d, input logic [1:0] p);
        access(1'b1, 1'b1, idx, d, p);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        #2;
    endtask

    task automatic t_reset();
        idle();
        check("R6 glob pulse low at reset", 64'(glob_chg_o), 64'd0);
        check("R11 win pulse low at reset", 64'(win_chg_o), 64'd0);
        rd(5'd16, H); check("R1 trap level", got_rd, 64'd6);
        rd(5'd19, H); check("R1 global level", got_rd, 64'd3);
        rd(5'd20, H); check("R1 hyper state", got_rd, 64'h24);
        rd(5'd6, H);  check("R1 soft interrupt", got_rd, 64'd0);
        rd(5'd13, H); check("R1 por trap type", got_rd, 64'd1);
        for (int i = 7; i <= 9; i++) begin
            rd(5'(i), H); check("R2 compare reset", got_rd, 64'h8000_0000_0000_0000);
        end
        rd(5'd3, U);
        check("R10 hidden tick user fault", 64'(got_flt), 64'd1);
        check("R10 hidden tick user data", got_rd, 64'd0);
        rd(5'd3, H);  check("R9 hide bit set by reset", 64'(got_rd[63]), 64'd1);
    endtask

    task automatic t_banking();
        wr(5'd16, 64'd1, H); wr(5'd10, 64'h111, H);
        wr(5'd16, 64'd2, H); wr(5'd10, 64'h222, H);
        rd(5'd10, H); check("R3 level 2 slot", got_rd, 64'h222);
        wr(5'd16, 64'd1, H);
        rd(5'd10, H); check("R3 level 1 slot kept", got_rd, 64'h111);
        wr(5'd13, 64'h4A, H);
        wr(5'd16, 64'd6, H);
        rd(5'd13, H); check("R3 top slot untouched", got_rd, 64'd1);
    endtask

    task automatic t_level_zero();
        wr(5'd16, 64'd0, U);
        rd(5'd11, H);
        check("R4 level0 read fault", 64'(got_flt), 64'd3);
        check("R4 level0 read data", got_rd, 64'd0);
        wr(5'd12, 64'h5, H);
        check("R4 level0 write fault", 64'(got_flt), 64'd3);
        wr(5'd16, 64'd1, H);
        rd(5'd12, H); check("R4 level0 write had no effect", got_rd, 64'd0);
    endtask

    task automatic t_clamp();
        wr(5'd16, 64'd9, H); rd(5'd16, H); check("R5 hyper cap", got_rd, 64'd6);
        wr(5'd16, 64'd5, S); rd(5'd16, H); check("R5 super cap", got_rd, 64'd2);
        wr(5'd16, 64'd5, U); rd(5'd16, H); check("R5 user as given", got_rd, 64'd5);
        wr(5'd19, 64'd7, H); rd(5'd19, H); check("R6 hyper cap", got_rd, 64'd3);
        wr(5'd19, 64'd3, S);
        idle();
        check("R6 glob pulse", 64'(glob_chg_o), 64'd1);
        check("R6 glob value", 64'(glob_lvl_o), 64'd2);
        idle();
        check("R6 glob pulse one cycle", 64'(glob_chg_o), 64'd0);
        wr(5'd19, 64'd1, U); rd(5'd19, H); check("R6 user as given", got_rd, 64'd1);
    endtask

    task automatic t_base_ver();
        wr(5'd14, 64'hFFFF_FFFF_FFFF_FFFF, S);
        rd(5'd14, S); check("R7 base low bits", got_rd, 64'hFFFF_FFFF_FFFF_8000);
        rd(5'd22, U); check("R8 version word", got_rd, 64'h0003_0608);
        wr(5'd22, 64'h1234, H); check("R8 version write fault", 64'(got_flt), 64'd3);
        rd(5'd22, H); check("R8 version unchanged", got_rd, 64'h0003_0608);
    endtask

    task automatic t_tick();
        wr(5'd3, 64'd1000, H);
        rd(5'd3, H); check("R9 tick +1", got_rd, 64'd1001);
        rd(5'd3, H); check("R9 tick +2", got_rd, 64'd1002);
        rd(5'd3, U); check("R9 user read open", got_rd, 64'd1003);
        wr(5'd3, 64'd7, U); check("R10 user write opcode fault", 64'(got_flt), 64'd2);
        wr(5'd3, 64'd7, S); check("R10 super write action fault", 64'(got_flt), 64'd1);
        rd(5'd3, H); check("R10 refused writes ignored", got_rd, 64'd1006);
        wr(5'd3, 64'h8000_0000_0000_0005, H);
        rd(5'd3, U);
        check("R10 hidden again fault", 64'(got_flt), 64'd1);
        check("R10 hidden again data", got_rd, 64'd0);
        rd(5'd3, H); check("R9 hide bit from write", got_rd, 64'h8000_0000_0000_0007);
    endtask

    task automatic t_window();
        wr(5'd18, 64'd5, U);
        idle();
        check("R11 win pulse", 64'(win_chg_o), 64'd1);
        check("R11 win value", 64'(win_ptr_o), 64'd5);
        idle();
        check("R11 win pulse one cycle", 64'(win_chg_o), 64'd0);
        rd(5'd18, U); check("R11 win readback", got_rd, 64'd5);
    endtask

    task automatic t_misc();
        wr(5'd4, 64'd8, H); check("R12 pc write", 64'(got_flt), 64'd3);
        rd(5'd4, H);        check("R12 pc read", 64'(got_flt), 64'd3);
        rd(5'd5, H);        check("R12 perf unimpl", 64'(got_flt), 64'd4);
        rd(5'd30, H);       check("R12 high index unimpl", 64'(got_flt), 64'd4);
        wr(5'd0, 64'h1234_5678_9ABC_DEF0, U);
        rd(5'd0, U); check("R13 plain readback", got_rd, 64'h1234_5678_9ABC_DEF0);
        access(1'b0, 1'b1, 5'd4, 64'd1, U);
        check("R13 no fault when idle", 64'(got_flt), 64'd0);
        access(1'b0, 1'b1, 5'd0, 64'hDEAD, U);
        rd(5'd0, U); check("R13 invalid write ignored", got_rd, 64'h1234_5678_9ABC_DEF0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        acc_idx = '0; acc_wdata = '0; acc_priv = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_banking();
        t_level_zero();
        t_clamp();
        t_base_ver();
        t_tick();
        t_window();
        t_misc();
        idle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule